// File: doc/BRIEF.md
# Front-to-Back Alpha Pixel Compositor

This block merges candidate pixels into one scan line, taking them in front-to-back order. Layer renderers present one candidate per clock: a pixel position, the layer number (a lower number is nearer the viewer), a 12-bit RGB colour, a 4-bit transparency (0 opaque, 15 fully clear), an index-zero flag and the layer's override and masking settings. Each line entry holds a state (uninitialised, holding a partly transparent colour, or opaque), a colour, a transparency and a layer floor. The block reports one cycle later whether deeper layers still have to supply that pixel, and which layer is the shallowest one still allowed to draw there.

Masking layers draw nothing themselves. A solid mask pixel raises the pixel's layer floor to a chosen deeper layer, so a whole consecutive run of layers behind the mask is skipped. A read port returns the finished line packed three pixels to a 36-bit word. A `line_start` pulse clears every entry for the next line.

Top module: `ftb_compositor`

## Requirements
- R1: Reset and `line_start` set every entry to uninitialised with floor 0. An uninitialised pixel reads as 0. `resp_valid` is low after reset. A candidate presented in the same cycle as `line_start` is dropped and gives no response.
- R2: The effective transparency is `lyr_ovr_alpha` when `lyr_ovr_en` is 1, and `cand_alpha` otherwise.
- R3: A candidate is empty and changes nothing when `cand_index_zero` is 1 (even under override) or when its effective transparency is 15.
- R4: An uninitialised pixel that takes a candidate with transparency 1..14 stores its colour and transparency, and stays incomplete (`resp_more`=1).
- R5: An uninitialised pixel that takes an opaque candidate (transparency 0) stores its colour and becomes complete (`resp_more`=0) in the same cycle that accepts it, with no extra cycles.
- R6: A transparent pixel (stored transparency a) that takes a transparent candidate with transparency b gets, for each 4-bit channel, (s*(15-a)+n*a+7)/15. Its new transparency is (a*b+7)/15, raised to 1 if that gives 0.
- R7: A transparent pixel that takes an opaque candidate mixes its colour by the same channel formula and becomes complete.
- R8: A complete pixel ignores all later candidates.
- R9: A candidate whose layer is below the pixel's floor is ignored. With `lyr_mask_en` set, a solid (transparency 0) non-empty candidate raises the floor to `lyr_mask_target` if the target is higher, and changes no colour or state. A non-solid mask candidate has no effect.
- R10: An accepted candidate (`cand_valid`, no `line_start`, `cand_x` below NPIX) produces, one cycle later, `resp_valid`=1 with `resp_x` equal to the position, `resp_more` and `resp_floor` giving the state after the update. A position at NPIX or above is ignored and gives no response.
- R11: Candidates for the same pixel in consecutive cycles each see the result of the one before.
- R12: `rd_word`, sampled one cycle after `rd_addr` is set, holds pixel 3*addr+k in bits [12k+11:12k] for k=0..2. Each 12-bit pixel is R in bits 11:8, G in 7:4 and B in 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Clear all entries for a new line |
| cand_valid | input | 1 | Candidate present |
| cand_x | input | X_W | Pixel position |
| cand_layer | input | L_W | Layer number, 0 is frontmost |
| cand_index_zero | input | 1 | Colour index was 0 (skipped pixel) |
| cand_rgb | input | 12 | Candidate colour |
| cand_alpha | input | 4 | Palette transparency |
| lyr_ovr_en | input | 1 | Layer transparency override enable |
| lyr_ovr_alpha | input | 4 | Override transparency |
| lyr_mask_en | input | 1 | Layer acts as a mask |
| lyr_mask_target | input | L_W | Layer to skip down to |
| rd_addr | input | A_W | Packed word address |
| rd_word | output | 36 | Three packed pixels |
| resp_valid | output | 1 | Response present |
| resp_x | output | X_W | Position of the response |
| resp_more | output | 1 | Pixel still needs deeper layers |
| resp_floor | output | L_W | Shallowest layer still allowed at this pixel |

## Verification
The response to a candidate is registered once, so the bench drives each candidate at a falling edge and checks `resp_*` at the next falling edge. At that point exactly one rising edge has passed. Entry writes land on that same edge. The read port adds one more register, so the bench sets `rd_addr` only after the last candidate has been written and compares `rd_word` one falling edge later. Every transparency pair from 1..14 over 0..14 is swept with a deeper opaque layer behind it, and directed sequences cover empties, overrides, masks, range and clearing.

// File: rtl/ftb_comp_pkg.sv
package ftb_comp_pkg;

  typedef enum logic [1:0] {
    PX_UNINIT = 2'd0,
    PX_TRANS  = 2'd1,
    PX_OPAQUE = 2'd2
  } px_state_e;

  typedef enum logic [1:0] {
    CK_EMPTY = 2'd0,
    CK_TRANS = 2'd1,
    CK_SOLID = 2'd2
  } cand_kind_e;

  typedef struct packed {
    px_state_e   st;
    logic [11:0] rgb;
    logic [3:0]  tr;
  } px_entry_t;

  // one channel: stored colour keeps (15-a)/15, newcomer fills a/15
  function automatic logic [3:0] mix_chan(input logic [3:0] s,
                                          input logic [3:0] n,
                                          input logic [3:0] a);
    logic [8:0] acc;
    acc = 9'(s) * 9'(4'd15 - a) + 9'(n) * 9'(a) + 9'd7;
    return 4'(acc / 9'd15);
  endfunction

  function automatic logic [11:0] mix_rgb(input logic [11:0] s,
                                          input logic [11:0] n,
                                          input logic [3:0]  a);
    return {mix_chan(s[11:8], n[11:8], a),
            mix_chan(s[7:4],  n[7:4],  a),
            mix_chan(s[3:0],  n[3:0],  a)};
  endfunction

  // stacked transparency, never reaching opaque from two clear-ish pixels
  function automatic logic [3:0] stack_tr(input logic [3:0] a,
                                          input logic [3:0] b);
    logic [8:0] p;
    logic [3:0] q;
    p = 9'(a) * 9'(b) + 9'd7;
    q = 4'(p / 9'd15);
    return (q == 4'd0) ? 4'd1 : q;
  endfunction

endpackage

// File: rtl/ftb_cand_resolve.sv
module ftb_cand_resolve
  import ftb_comp_pkg::*;
(
  input  logic       index_zero,
  input  logic [3:0] pal_alpha,
  input  logic       ovr_en,
  input  logic [3:0] ovr_alpha,
  output logic [3:0] eff_alpha,
  output cand_kind_e kind
);

  always_comb begin
    eff_alpha = ovr_en ? ovr_alpha : pal_alpha;
    if (index_zero || eff_alpha == 4'd15) kind = CK_EMPTY;
    else if (eff_alpha == 4'd0)           kind = CK_SOLID;
    else                                  kind = CK_TRANS;
  end

endmodule

// File: rtl/ftb_pixel_merge.sv
module ftb_pixel_merge
  import ftb_comp_pkg::*;
#(
  parameter int L_W = 3
) (
  input  px_entry_t        cur,
  input  logic [L_W-1:0]   cur_floor,
  input  logic [L_W-1:0]   layer,
  input  cand_kind_e       kind,
  input  logic [11:0]      rgb,
  input  logic [3:0]       eff_alpha,
  input  logic             mask_en,
  input  logic [L_W-1:0]   mask_target,
  output px_entry_t        nxt,
  output logic [L_W-1:0]   nxt_floor
);

  logic skip;

  always_comb begin
    nxt       = cur;
    nxt_floor = cur_floor;
    skip      = (cur.st == PX_OPAQUE) || (layer < cur_floor) || (kind == CK_EMPTY);
    if (!skip) begin
      if (mask_en) begin
        if (kind == CK_SOLID && mask_target > cur_floor) nxt_floor = mask_target;
      end else begin
        case (cur.st)
          PX_UNINIT: begin
            nxt.rgb = rgb;
            nxt.tr  = eff_alpha;
            nxt.st  = (kind == CK_SOLID) ? PX_OPAQUE : PX_TRANS;
          end
          PX_TRANS: begin
            nxt.rgb = mix_rgb(cur.rgb, rgb, cur.tr);
            if (kind == CK_SOLID) begin
              nxt.st = PX_OPAQUE;
              nxt.tr = 4'd0;
            end else begin
              nxt.tr = stack_tr(cur.tr, eff_alpha);
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ftb_line_packer.sv
module ftb_line_packer #(
  parameter int NPIX = 12,
  localparam int WORDS = NPIX / 3,
  localparam int A_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIX*12-1:0] line_pix,
  input  logic [A_W-1:0]    rd_addr,
  output logic [35:0]       rd_word
);

  logic [35:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign words[w] = line_pix[w*36 +: 36];
  end

  always_ff @(posedge clk) begin
    if (rst)                                         rd_word <= '0;
    else if ({1'b0, rd_addr} < (A_W+1)'(WORDS))      rd_word <= words[rd_addr];
    else                                             rd_word <= '0;
  end

endmodule

// File: rtl/ftb_compositor.sv
module ftb_compositor
  import ftb_comp_pkg::*;
#(
  parameter int NPIX   = 12,   // multiple of 3
  parameter int NLAYER = 8,
  localparam int L_W   = (NLAYER > 1) ? $clog2(NLAYER) : 1,
  localparam int X_W   = $clog2(NPIX),
  localparam int WORDS = NPIX / 3,
  localparam int A_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           line_start,
  input  logic           cand_valid,
  input  logic [X_W-1:0] cand_x,
  input  logic [L_W-1:0] cand_layer,
  input  logic           cand_index_zero,
  input  logic [11:0]    cand_rgb,
  input  logic [3:0]     cand_alpha,
  input  logic           lyr_ovr_en,
  input  logic [3:0]     lyr_ovr_alpha,
  input  logic           lyr_mask_en,
  input  logic [L_W-1:0] lyr_mask_target,
  input  logic [A_W-1:0] rd_addr,
  output logic [35:0]    rd_word,
  output logic           resp_valid,
  output logic [X_W-1:0] resp_x,
  output logic           resp_more,
  output logic [L_W-1:0] resp_floor
);

  px_entry_t      ent [NPIX];
  logic [L_W-1:0] flr [NPIX];

  logic           x_ok, accept;
  logic [X_W-1:0] idx;
  logic [3:0]     eff_alpha;
  cand_kind_e     kind;
  px_entry_t      nxt;
  logic [L_W-1:0] nxt_floor;
  logic [NPIX*12-1:0] line_pix;

  assign x_ok   = {1'b0, cand_x} < (X_W+1)'(NPIX);
  assign idx    = x_ok ? cand_x : '0;
  assign accept = cand_valid && !line_start && x_ok;

  ftb_cand_resolve u_resolve (
    .index_zero (cand_index_zero),
    .pal_alpha  (cand_alpha),
    .ovr_en     (lyr_ovr_en),
    .ovr_alpha  (lyr_ovr_alpha),
    .eff_alpha  (eff_alpha),
    .kind       (kind)
  );

  ftb_pixel_merge #(.L_W(L_W)) u_merge (
    .cur         (ent[idx]),
    .cur_floor   (flr[idx]),
    .layer       (cand_layer),
    .kind        (kind),
    .rgb         (cand_rgb),
    .eff_alpha   (eff_alpha),
    .mask_en     (lyr_mask_en),
    .mask_target (lyr_mask_target),
    .nxt         (nxt),
    .nxt_floor   (nxt_floor)
  );

  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      for (int i = 0; i < NPIX; i++) begin
        ent[i] <= '{st: PX_UNINIT, rgb: 12'd0, tr: 4'd0};
        flr[i] <= '0;
      end
    end else if (accept) begin
      ent[idx] <= nxt;
      flr[idx] <= nxt_floor;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_x     <= '0;
      resp_more  <= 1'b0;
      resp_floor <= '0;
    end else begin
      resp_valid <= accept;
      if (accept) begin
        resp_x     <= cand_x;
        resp_more  <= (nxt.st != PX_OPAQUE);
        resp_floor <= nxt_floor;
      end
    end
  end

  for (genvar p = 0; p < NPIX; p++) begin : g_disp
    assign line_pix[p*12 +: 12] = (ent[p].st == PX_UNINIT) ? 12'd0 : ent[p].rgb;
  end

  ftb_line_packer #(.NPIX(NPIX)) u_pack (
    .clk      (clk),
    .rst      (rst),
    .line_pix (line_pix),
    .rd_addr  (rd_addr),
    .rd_word  (rd_word)
  );

endmodule

// File: rtl/ftb_compositor_chk.sv
module ftb_compositor_chk #(
  parameter int NPIX = 12,
  parameter int L_W  = 3,
  parameter int X_W  = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           line_start,
  input logic           cand_valid,
  input logic [X_W-1:0] cand_x,
  input logic           resp_valid,
  input logic [X_W-1:0] resp_x,
  input logic           resp_more,
  input logic [L_W-1:0] resp_floor
);

  logic in_range;
  assign in_range = {1'b0, cand_x} < (X_W+1)'(NPIX);

  assert_resp_follows_R10: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && !line_start && in_range) |=> (resp_valid && resp_x == $past(cand_x)));

  assert_range_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && !in_range) |=> !resp_valid);

  assert_clear_drops_R1: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !resp_valid);

  assert_opaque_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_more && cand_valid && !line_start && cand_x == resp_x) |=> !resp_more);

  assert_floor_rises_R9: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && cand_valid && !line_start && cand_x == resp_x) |=> (resp_floor >= $past(resp_floor)));

endmodule

bind ftb_compositor ftb_compositor_chk #(.NPIX(NPIX), .L_W(L_W), .X_W(X_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .line_start (line_start),
  .cand_valid (cand_valid),
  .cand_x     (cand_x),
  .resp_valid (resp_valid),
  .resp_x     (resp_x),
  .resp_more  (resp_more),
  .resp_floor (resp_floor)
);

// File: tb/ftb_compositor_tb.sv
`timescale 1ns/1ps
module ftb_compositor_tb;
  localparam int NPIX = 12;
  localparam int NLAYER = 8;
  localparam int L_W = 3;
  localparam int X_W = 4;
  localparam int A_W = 2;
  localparam int WORDS = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, line_start, cand_valid, cand_index_zero, lyr_ovr_en, lyr_mask_en;
  logic [X_W-1:0] cand_x;
  logic [L_W-1:0] cand_layer, lyr_mask_target;
  logic [11:0] cand_rgb;
  logic [3:0] cand_alpha, lyr_ovr_alpha;
  logic [A_W-1:0] rd_addr;
  logic [35:0] rd_word;
  logic resp_valid, resp_more;
  logic [X_W-1:0] resp_x;
  logic [L_W-1:0] resp_floor;

  ftb_compositor #(.NPIX(NPIX), .NLAYER(NLAYER)) u_dut (
    .clk(clk), .rst(rst), .line_start(line_start), .cand_valid(cand_valid),
    .cand_x(cand_x), .cand_layer(cand_layer), .cand_index_zero(cand_index_zero),
    .cand_rgb(cand_rgb), .cand_alpha(cand_alpha), .lyr_ovr_en(lyr_ovr_en),
    .lyr_ovr_alpha(lyr_ovr_alpha), .lyr_mask_en(lyr_mask_en),
    .lyr_mask_target(lyr_mask_target), .rd_addr(rd_addr), .rd_word(rd_word),
    .resp_valid(resp_valid), .resp_x(resp_x), .resp_more(resp_more),
    .resp_floor(resp_floor)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  int m_st [NPIX];
  int m_rgb[NPIX];
  int m_tr [NPIX];
  int m_fl [NPIX];
  int e_more, e_floor;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int mixc(int s, int n, int a);
    return (s * (15 - a) + n * a + 7) / 15;
  endfunction

  function automatic int mixrgb(int s, int n, int a);
    int r = 0;
    for (int k = 0; k < 3; k++)
      r = r | (mixc((s >> (4*k)) & 15, (n >> (4*k)) & 15, a) << (4*k));
    return r;
  endfunction

  function automatic int stacktr(int a, int b);
    int p = (a * b + 7) / 15;
    return (p == 0) ? 1 : p;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NPIX; i++) begin
      m_st[i] = 0; m_rgb[i] = 0; m_tr[i] = 0; m_fl[i] = 0;
    end
  endtask

  task automatic model(int x, int layer, int iz, int rgb, int al, int oe, int oa, int me, int mt);
    int ea = (oe != 0) ? oa : al;
    bit empty = (iz != 0) || (ea == 15);
    if (!(m_st[x] == 2 || layer < m_fl[x] || empty)) begin
      if (me != 0) begin
        if (ea == 0 && mt > m_fl[x]) m_fl[x] = mt;
      end else if (m_st[x] == 0) begin
        m_rgb[x] = rgb; m_tr[x] = ea; m_st[x] = (ea == 0) ? 2 : 1;
      end else begin
        m_rgb[x] = mixrgb(m_rgb[x], rgb, m_tr[x]);
        if (ea == 0) begin m_st[x] = 2; m_tr[x] = 0; end
        else m_tr[x] = stacktr(m_tr[x], ea);
      end
    end
    e_more = (m_st[x] != 2) ? 1 : 0;
    e_floor = m_fl[x];
  endtask

  task automatic cand(string req, int x, int layer, int iz, int rgb, int al,
                      int oe, int oa, int me, int mt);
    line_start = 0;
    cand_valid = 1;
    cand_x = X_W'(x);
    cand_layer = L_W'(layer);
    cand_index_zero = (iz != 0);
    cand_rgb = 12'(rgb);
    cand_alpha = 4'(al);
    lyr_ovr_en = (oe != 0);
    lyr_ovr_alpha = 4'(oa);
    lyr_mask_en = (me != 0);
    lyr_mask_target = L_W'(mt);
    model(x, layer, iz, rgb, al, oe, oa, me, mt);
    @(negedge clk);
    check(req, "resp_valid", int'(resp_valid), 1);
    check(req, "resp_x", int'(resp_x), x);
    check(req, "resp_more", int'(resp_more), e_more);
    check(req, "resp_floor", int'(resp_floor), e_floor);
  endtask

  task automatic draw(string req, int x, int layer, int rgb, int al);
    cand(req, x, layer, 0, rgb, al, 0, 0, 0, 0);
  endtask

  task automatic clear_line();
    cand_valid = 0;
    line_start = 1;
    @(negedge clk);
    line_start = 0;
    model_clear();
    check("R1", "resp_valid after clear", int'(resp_valid), 0);
  endtask

  task automatic read_chk(string req, int a);
    cand_valid = 0;
    line_start = 0;
    rd_addr = A_W'(a);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      int p = 3 * a + k;
      int e = (m_st[p] == 0) ? 0 : m_rgb[p];
      check(req, $sformatf("pixel %0d", p), int'(rd_word[k*12 +: 12]), e);
    end
  endtask

  initial begin
    rst = 1; line_start = 0; cand_valid = 0; cand_x = '0; cand_layer = '0;
    cand_index_zero = 0; cand_rgb = '0; cand_alpha = '0; lyr_ovr_en = 0;
    lyr_ovr_alpha = '0; lyr_mask_en = 0; lyr_mask_target = '0; rd_addr = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1", "resp_valid after reset", int'(resp_valid), 0);
    for (int a = 0; a < WORDS; a++) read_chk("R1", a);

    // R4/R6/R7/R8 sweep over transparency pairs, with an opaque layer behind
    for (int as = 1; as <= 14; as++) begin
      for (int an = 0; an <= 14; an++) begin
        int x = (as * 3 + an) % NPIX;
        int c1 = (as * 37 + an * 11 + 3) & 12'hfff;
        int c2 = (an * 293 + as * 7 + 5) & 12'hfff;
        int c3 = (as * an * 19 + 12'h9a5) & 12'hfff;
        string t2 = (an == 0) ? "R7" : "R6";
        string t3 = (an == 0) ? "R8" : "R7";
        clear_line();
        draw("R4", x, 0, c1, as);
        draw(t2, x, 1, c2, an);
        read_chk(t2, x / 3);
        draw(t3, x, 2, c3, 0);
        read_chk(t3, x / 3);
      end
    end

    // R5: direct opaque, R12: packing of three neighbours
    clear_line();
    draw("R5", 3, 0, 12'h123, 0);
    draw("R12", 4, 2, 12'hab7, 0);
    draw("R12", 5, 6, 12'hf0e, 0);
    read_chk("R12", 1);
    draw("R8", 3, 1, 12'h777, 0);
    read_chk("R8", 1);

    // R3: empties from uninit and from transparent
    clear_line();
    cand("R3", 6, 0, 1, 12'h555, 0, 0, 0, 0, 0);
    draw("R3", 6, 1, 12'h444, 15);
    read_chk("R3", 2);
    draw("R4", 6, 2, 12'h9c3, 5);
    cand("R3", 6, 3, 1, 12'hfff, 0, 0, 0, 0, 0);
    cand("R3", 6, 4, 0, 12'hfff, 0, 1, 15, 0, 0);
    read_chk("R3", 2);
    draw("R7", 6, 5, 12'h0f0, 0);
    read_chk("R7", 2);

    // R2: override in both directions, and index zero wins over override
    clear_line();
    cand("R2", 7, 0, 0, 12'h8a1, 0, 1, 8, 0, 0);
    cand("R2", 7, 1, 0, 12'h1f6, 9, 1, 0, 0, 0);
    read_chk("R2", 2);
    cand("R2", 8, 0, 1, 12'h333, 9, 1, 0, 0, 0);
    read_chk("R2", 2);

    // R9: masking raises the floor and skips a run of layers
    clear_line();
    cand("R9", 9, 1, 0, 12'hbbb, 6, 0, 0, 1, 6);
    cand("R9", 9, 1, 0, 12'hbbb, 0, 0, 0, 1, 5);
    draw("R9", 9, 3, 12'h321, 0);
    draw("R9", 9, 4, 12'h654, 7);
    cand("R9", 9, 2, 0, 12'h000, 0, 0, 0, 1, 2);
    read_chk("R9", 3);
    cand("R9", 9, 6, 0, 12'h000, 0, 0, 0, 1, 7);
    draw("R9", 9, 5, 12'h987, 0);
    draw("R9", 9, 7, 12'h4e2, 4);
    read_chk("R9", 3);
    draw("R9", 9, 7, 12'h2d9, 0);
    read_chk("R9", 3);

    // R11: back-to-back on one pixel, then interleaved pixels
    clear_line();
    draw("R11", 10, 0, 12'h6a2, 6);
    draw("R11", 10, 1, 12'h1b8, 3);
    draw("R11", 11, 0, 12'hc4d, 11);
    draw("R11", 10, 2, 12'he07, 0);
    draw("R11", 11, 1, 12'h58a, 2);
    draw("R11", 10, 3, 12'h000, 0);
    read_chk("R11", 3);

    // R10: out-of-range position gives no response and no change
    cand_valid = 1; cand_x = X_W'(13); cand_layer = '0; cand_index_zero = 0;
    cand_alpha = '0; lyr_ovr_en = 0; lyr_mask_en = 0; cand_rgb = 12'hfff;
    @(negedge clk);
    check("R10", "resp_valid out of range", int'(resp_valid), 0);
    read_chk("R10", 3);

    // R1: candidate alongside line_start is dropped, line is cleared
    draw("R1", 2, 0, 12'h3c3, 0);
    cand_valid = 1; line_start = 1; cand_x = X_W'(1); cand_alpha = '0; cand_rgb = 12'habc;
    @(negedge clk);
    line_start = 0; cand_valid = 0;
    model_clear();
    check("R1", "resp_valid with line_start", int'(resp_valid), 0);
    read_chk("R1", 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule